// File: doc/BRIEF.md
# Transmit Link Phase Sequencer

This block steps the transmit side of a serial converter link through its three start-up phases. In the first phase it sends comma characters (K28.5: octet 0xBC with the control flag set). In the second it passes through an externally generated lane alignment stream. In the third it passes user data. It watches an active-low synchronization request from the receiver, a frame-boundary strobe and a multiframe-boundary strobe. A subclass setting chooses which of the two strobes ends the comma phase. A lane-alignment enable bit can skip the alignment phase, and a length field sets how long the alignment phase lasts in subclass 0.

Each strobe is a single-cycle pulse asserted in the last cycle before a boundary. A phase change therefore takes effect on the clock edge that closes the strobe cycle, so the first octet of the new phase falls exactly on the boundary. The request input is asynchronous. It passes through a two-stage synchronizer, and a release is only armed once the synchronized level shows high after low. Lane octets are carried `OCTETS` at a time, and the control flags are per octet.

Top module: `link_phase_ctrl`

## Requirements
- R1: During and right after reset, `phase_o` is 2'b00, `align_start_o` is 0, and every output octet is 0xBC with its `tx_k_o` bit set.
- R2: While the synchronized request is low, the phase stays 2'b00 whatever the strobes do, and every octet is 0xBC with its K flag set.
- R3: In subclass 0 (`subclass_i` = 0), after a release the phase leaves 2'b00 only on the edge that closes a `frame_bnd_i` cycle; `mf_bnd_i` strobes do not move it.
- R4: In subclasses 1 and 2 (`subclass_i` nonzero), after a release the phase leaves 2'b00 on the first `mf_bnd_i` strobe; `frame_bnd_i` strobes do not move it.
- R5: With `align_en_i` = 0, the comma phase exits directly to user data (2'b10) and `align_start_o` stays 0.
- R6: With `align_en_i` = 1, the comma phase exits to alignment (2'b01). `align_start_o` is high for exactly the first alignment cycle, and the outputs equal `align_data_i`/`align_k_i` during alignment.
- R7: In subclasses 1 and 2, alignment lasts exactly four multiframes: the phase becomes 2'b10 on the fourth `mf_bnd_i` strobe seen during alignment, and `align_len_i` is ignored.
- R8: In subclass 0, alignment lasts `align_len_i`+1 multiframes (1 to 256). The phase becomes 2'b10 on that strobe, and `frame_bnd_i` has no effect during alignment.
- R9: In the user data phase, `tx_data_o` equals `user_data_i` and all `tx_k_o` bits are 0.
- R10: If the request input goes low during alignment or user data, the phase is 2'b00 by the third rising edge after the change: two synchronizer edges and one state edge.
- R11: A release is acted on only after the synchronizer and the arming register. A boundary strobe captured on the first, second or third edge after the input rises is ignored; one captured on the fourth edge is honored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_req_ni | input | 1 | Asynchronous synchronization request, low = request |
| frame_bnd_i | input | 1 | Pulse in the last cycle before a frame boundary |
| mf_bnd_i | input | 1 | Pulse in the last cycle before a multiframe boundary |
| subclass_i | input | 2 | Link subclass, 0 selects frame-boundary exit |
| align_en_i | input | 1 | Enable the lane alignment phase |
| align_len_i | input | LEN_W | Subclass 0 alignment length in multiframes minus one |
| align_data_i | input | 8*OCTETS | Alignment stream octets |
| align_k_i | input | OCTETS | Alignment stream control flags |
| user_data_i | input | 8*OCTETS | User data octets |
| phase_o | output | 2 | 00 comma, 01 alignment, 10 user data |
| align_start_o | output | 1 | Pulse in the first alignment cycle |
| tx_data_o | output | 8*OCTETS | Selected lane octets |
| tx_k_o | output | OCTETS | Selected control flags |

## Verification
The assertions assume that `subclass_i` and `align_en_i` only change while the phase is 2'b00, and that each strobe is a single-cycle pulse. They also assume `phase_o` is only ever one of the three defined codes. The stimulus changes the configuration only while the request is asserted, before each release. It raises every strobe for exactly one clock, driven on the falling edge. Tests that leave one phase and enter another first return the block to the comma phase by asserting the request.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [1:0] {
    PH_CGS   = 2'b00,
    PH_ALIGN = 2'b01,
    PH_DATA  = 2'b10
  } phase_e;

  localparam logic [7:0] COMMA_OCTET = 8'hBC;
endpackage

// File: rtl/lpc_sync.sv
module lpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  // reset value 0 = request asserted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lpc_release_det.sv
module lpc_release_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_lvl_i,
  output logic armed_o
);
  logic prev_q;
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q <= req_lvl_i;
      if (!req_lvl_i)          armed_q <= 1'b0;
      else if (!prev_q)        armed_q <= 1'b1;
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/lpc_phase_fsm.sv
module lpc_phase_fsm
  import lpc_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int STD_MF = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_lvl_i,
  input  logic             armed_i,
  input  logic             frame_bnd_i,
  input  logic             mf_bnd_i,
  input  logic [1:0]       subclass_i,
  input  logic             align_en_i,
  input  logic [LEN_W-1:0] align_len_i,
  output phase_e           phase_o,
  output logic             align_start_o
);
  localparam logic [LEN_W-1:0] STD_LAST = LEN_W'(STD_MF - 1);

  phase_e           phase_q, phase_d;
  logic [LEN_W-1:0] mf_cnt_q;
  logic [LEN_W-1:0] last_mf;
  logic             exit_bnd;
  logic             start_q;

  assign exit_bnd = (subclass_i == 2'd0) ? frame_bnd_i : mf_bnd_i;
  assign last_mf  = (subclass_i == 2'd0) ? align_len_i : STD_LAST;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_CGS: begin
        if (req_lvl_i && armed_i && exit_bnd)
          phase_d = align_en_i ? PH_ALIGN : PH_DATA;
      end
      PH_ALIGN: begin
        if (!req_lvl_i)                       phase_d = PH_CGS;
        else if (mf_bnd_i && mf_cnt_q == last_mf) phase_d = PH_DATA;
      end
      PH_DATA: begin
        if (!req_lvl_i) phase_d = PH_CGS;
      end
      default: phase_d = PH_CGS;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_CGS;
      mf_cnt_q <= '0;
      start_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      start_q <= (phase_q == PH_CGS) && (phase_d == PH_ALIGN);
      if (phase_d != PH_ALIGN || phase_q != PH_ALIGN) mf_cnt_q <= '0;
      else if (mf_bnd_i)                              mf_cnt_q <= mf_cnt_q + 1'b1;
    end
  end

  assign phase_o       = phase_q;
  assign align_start_o = start_q;
endmodule

// File: rtl/lpc_tx_mux.sv
module lpc_tx_mux
  import lpc_pkg::*;
#(
  parameter int OCTETS = 1
) (
  input  phase_e                phase_i,
  input  logic [8*OCTETS-1:0]   align_data_i,
  input  logic [OCTETS-1:0]     align_k_i,
  input  logic [8*OCTETS-1:0]   user_data_i,
  output logic [8*OCTETS-1:0]   tx_data_o,
  output logic [OCTETS-1:0]     tx_k_o
);
  for (genvar g = 0; g < OCTETS; g++) begin : g_oct
    always_comb begin
      unique case (phase_i)
        PH_ALIGN: begin
          tx_data_o[8*g +: 8] = align_data_i[8*g +: 8];
          tx_k_o[g]           = align_k_i[g];
        end
        PH_DATA: begin
          tx_data_o[8*g +: 8] = user_data_i[8*g +: 8];
          tx_k_o[g]           = 1'b0;
        end
        default: begin
          tx_data_o[8*g +: 8] = COMMA_OCTET;
          tx_k_o[g]           = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/link_phase_ctrl.sv
module link_phase_ctrl
  import lpc_pkg::*;
#(
  parameter int OCTETS      = 1,
  parameter int LEN_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int STD_MF      = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sync_req_ni,
  input  logic                  frame_bnd_i,
  input  logic                  mf_bnd_i,
  input  logic [1:0]            subclass_i,
  input  logic                  align_en_i,
  input  logic [LEN_W-1:0]      align_len_i,
  input  logic [8*OCTETS-1:0]   align_data_i,
  input  logic [OCTETS-1:0]     align_k_i,
  input  logic [8*OCTETS-1:0]   user_data_i,
  output logic [1:0]            phase_o,
  output logic                  align_start_o,
  output logic [8*OCTETS-1:0]   tx_data_o,
  output logic [OCTETS-1:0]     tx_k_o
);
  logic   req_lvl;
  logic   armed;
  phase_e phase;

  lpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_req_ni),
    .q_o   (req_lvl)
  );

  lpc_release_det u_rel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_lvl_i(req_lvl),
    .armed_o  (armed)
  );

  lpc_phase_fsm #(.LEN_W(LEN_W), .STD_MF(STD_MF)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_lvl_i    (req_lvl),
    .armed_i      (armed),
    .frame_bnd_i  (frame_bnd_i),
    .mf_bnd_i     (mf_bnd_i),
    .subclass_i   (subclass_i),
    .align_en_i   (align_en_i),
    .align_len_i  (align_len_i),
    .phase_o      (phase),
    .align_start_o(align_start_o)
  );

  lpc_tx_mux #(.OCTETS(OCTETS)) u_mux (
    .phase_i     (phase),
    .align_data_i(align_data_i),
    .align_k_i   (align_k_i),
    .user_data_i (user_data_i),
    .tx_data_o   (tx_data_o),
    .tx_k_o      (tx_k_o)
  );

  assign phase_o = phase;
endmodule

// File: rtl/link_phase_ctrl_chk.sv
module link_phase_ctrl_chk #(
  parameter int OCTETS = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        phase_o,
  input logic              align_start_o,
  input logic [OCTETS-1:0] tx_k_o,
  input logic [1:0]        subclass_i,
  input logic              align_en_i,
  input logic              frame_bnd_i,
  input logic              mf_bnd_i
);
  // R1
  legal_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != 2'b11);

  // R2
  comma_k_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'b00) |-> (tx_k_o == {OCTETS{1'b1}}));

  // R3
  sc0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'b00 && subclass_i == 2'd0 && !frame_bnd_i) |=> (phase_o == 2'b00));

  // R4
  sc12_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'b00 && subclass_i != 2'd0 && !mf_bnd_i) |=> (phase_o == 2'b00));

  // R5
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'b00 && !align_en_i) |=> (phase_o != 2'b01));

  // R6
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_start_o |-> (phase_o == 2'b01 && $past(phase_o) == 2'b00));

  // R7
  align_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'b01 && !mf_bnd_i) |=> (phase_o != 2'b10));

  // R10
  data_no_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'b10) |=> (phase_o != 2'b01));
endmodule

bind link_phase_ctrl link_phase_ctrl_chk #(.OCTETS(OCTETS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .phase_o      (phase_o),
  .align_start_o(align_start_o),
  .tx_k_o       (tx_k_o),
  .subclass_i   (subclass_i),
  .align_en_i   (align_en_i),
  .frame_bnd_i  (frame_bnd_i),
  .mf_bnd_i     (mf_bnd_i)
);

// File: tb/link_phase_ctrl_test.sv
`timescale 1ns/1ps
module link_phase_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_req_ni = 1'b0;
  logic       frame_bnd_i = 1'b0;
  logic       mf_bnd_i = 1'b0;
  logic [1:0] subclass_i = 2'd0;
  logic       align_en_i = 1'b1;
  logic [7:0] align_len_i = 8'd0;
  logic [7:0] align_data_i = 8'h1C;
  logic [0:0] align_k_i = 1'b1;
  logic [7:0] user_data_i = 8'hA5;
  logic [1:0] phase_o;
  logic       align_start_o;
  logic [7:0] tx_data_o;
  logic [0:0] tx_k_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  link_phase_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .sync_req_ni(sync_req_ni),
    .frame_bnd_i(frame_bnd_i), .mf_bnd_i(mf_bnd_i), .subclass_i(subclass_i),
    .align_en_i(align_en_i), .align_len_i(align_len_i),
    .align_data_i(align_data_i), .align_k_i(align_k_i), .user_data_i(user_data_i),
    .phase_o(phase_o), .align_start_o(align_start_o),
    .tx_data_o(tx_data_o), .tx_k_o(tx_k_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_frame();
    frame_bnd_i = 1'b1; @(negedge clk); frame_bnd_i = 1'b0;
  endtask

  task automatic pulse_mf();
    mf_bnd_i = 1'b1; @(negedge clk); mf_bnd_i = 1'b0;
  endtask

  task automatic release_req();
    sync_req_ni = 1'b1; clk_n(4);
  endtask

  task automatic reassert();
    sync_req_ni = 1'b0; clk_n(3);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; clk_n(2);
    check("R1 phase in reset", phase_o, 2'b00);
    check("R1 start in reset", align_start_o, 1'b0);
    rst_ni = 1'b1; clk_n(1);
    check("R1 data after reset", {tx_k_o, tx_data_o}, {1'b1, 8'hBC});
    check("R1 phase after reset", phase_o, 2'b00);
  endtask

  task automatic t_comma_hold();
    subclass_i = 2'd0; pulse_frame(); pulse_mf(); clk_n(2);
    check("R2 phase held", phase_o, 2'b00);
    check("R2 comma", {tx_k_o, tx_data_o}, {1'b1, 8'hBC});
  endtask

  task automatic t_sc0_path();
    subclass_i = 2'd0; align_en_i = 1'b1; align_len_i = 8'd2;
    release_req();
    pulse_mf();
    check("R3 mf ignored in sc0", phase_o, 2'b00);
    pulse_frame();
    check("R3 frame exit", phase_o, 2'b01);
    check("R6 start pulse", align_start_o, 1'b1);
    check("R6 align data", {tx_k_o, tx_data_o}, {1'b1, 8'h1C});
    clk_n(1);
    check("R6 start one cycle", align_start_o, 1'b0);
    pulse_frame(); pulse_mf(); pulse_mf();
    check("R8 still aligning", phase_o, 2'b01);
    pulse_mf();
    check("R8 len+1 multiframes", phase_o, 2'b10);
    check("R9 user data", {tx_k_o, tx_data_o}, {1'b0, 8'hA5});
    user_data_i = 8'h3C; #0.1;
    check("R9 user data follows", {tx_k_o, tx_data_o}, {1'b0, 8'h3C});
    reassert();
    check("R10 back to comma", phase_o, 2'b00);
    check("R10 comma output", {tx_k_o, tx_data_o}, {1'b1, 8'hBC});
  endtask

  task automatic t_sc1_path();
    subclass_i = 2'd1; align_en_i = 1'b1; align_len_i = 8'd0;
    release_req();
    pulse_frame();
    check("R4 frame ignored in sc1", phase_o, 2'b00);
    pulse_mf();
    check("R4 mf exit", phase_o, 2'b01);
    pulse_mf(); pulse_mf(); pulse_mf();
    check("R7 three mf still aligning", phase_o, 2'b01);
    pulse_mf();
    check("R7 four multiframes", phase_o, 2'b10);
    sync_req_ni = 1'b0; clk_n(2);
    user_data_i = 8'h5A; clk_n(1);
    check("R10 return from data", phase_o, 2'b00);
  endtask

  task automatic t_sc1_realign();
    subclass_i = 2'd1; align_en_i = 1'b1;
    release_req(); pulse_mf(); pulse_mf();
    reassert();
    check("R10 return from align", phase_o, 2'b00);
  endtask

  task automatic t_bypass();
    subclass_i = 2'd2; align_en_i = 1'b0;
    release_req();
    pulse_mf();
    check("R5 direct to data", phase_o, 2'b10);
    check("R5 no start pulse", align_start_o, 1'b0);
    reassert();
  endtask

  task automatic t_arm_latency();
    subclass_i = 2'd0; align_en_i = 1'b1; align_len_i = 8'd0;
    sync_req_ni = 1'b1;
    pulse_frame();
    check("R11 strobe at edge 1 ignored", phase_o, 2'b00);
    pulse_frame();
    check("R11 strobe at edge 2 ignored", phase_o, 2'b00);
    pulse_frame();
    check("R11 strobe at edge 3 ignored", phase_o, 2'b00);
    pulse_frame();
    check("R11 strobe at edge 4 honored", phase_o, 2'b01);
    pulse_mf();
    check("R8 single multiframe", phase_o, 2'b10);
    reassert();
  endtask

  initial begin
    clk_n(1);
    t_reset();
    t_comma_hold();
    t_sc0_path();
    t_sc1_path();
    t_sc1_realign();
    t_bypass();
    t_arm_latency();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule